// File: doc/BRIEF.md
# Windowed Bus Performance Counter

This block watches one request/response port of a memory-mapped bus, for example the read side of a burst bus. A request counts as accepted on a clock edge where both its valid and ready are high. Each response beat is a clock edge where the response valid and ready are both high, and a last flag marks the final beat of a burst. Responses are taken to return in request order, and up to `DEPTH` requests may be outstanding at once. For every completed transaction the block measures two figures. The first is the latency, counted from acceptance to the first response beat. The second is the access time, counted from acceptance to the last beat.

Time is split into sampling windows of `cfg_period` clock edges. Within a window the block sums the completed transactions, their latencies and their access times. It also counts how many of those transactions had a latency inside a programmable inclusive range. When a window closes, the four totals and an overflow flag are copied into snapshot outputs, and `snap_valid` pulses for one cycle so that a host link can forward them. The accumulators then restart at zero without dropping the event on the closing edge. A period of zero stops the windows, and totals keep building until a non-zero period is set.

Top module: `busperf_window`

## Requirements
- R1: The latency of a transaction is the number of clock edges from its request acceptance edge to its first response beat edge. A single-beat transaction with a beat one edge after acceptance has latency 1.
- R2: The access time of a transaction is the number of clock edges from its acceptance edge to its last response beat edge, that is the latency plus the number of beats minus one.
- R3: Up to `DEPTH` requests may be outstanding. Responses are matched to requests in acceptance order, and a transaction is counted in the window that holds its last beat.
- R4: The in-range count rises by one for each completed transaction whose latency L meets `cfg_lat_lo <= L <= cfg_lat_hi`, both bounds included.
- R5: With a non-zero period P, a window closes on every P-th clock edge. `snap_valid` is high for exactly the one cycle after that edge, and the snapshot outputs hold their values until the next window closes.
- R6: A transaction whose last beat falls on a window's closing edge is reported in that window. The next window starts empty and contains only events from later edges.
- R7: While `cfg_period` is 0 no snapshot is produced and the totals keep accumulating. A change to period 1 closes a window on the next edge that holds everything gathered so far.
- R8: Each total saturates at its all-ones value instead of wrapping. `snap_ovf` reports whether any total saturated during that window, and the flag starts clear in the following window.
- R9: After reset `snap_valid` is 0 and every snapshot output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | PER_W | Window length in clock edges, 0 disables windows |
| cfg_lat_lo | input | TS_W | Lower bound of the latency range, inclusive |
| cfg_lat_hi | input | TS_W | Upper bound of the latency range, inclusive |
| req_valid | input | 1 | Request valid on the observed port |
| req_ready | input | 1 | Request ready on the observed port |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | input | 1 | Response beat ready |
| rsp_last | input | 1 | Marks the final beat of a response |
| snap_valid | output | 1 | One-cycle pulse after a window closes |
| snap_txn | output | TXN_W | Completed transactions in the window |
| snap_lat | output | CYC_W | Sum of latencies in the window |
| snap_acc | output | CYC_W | Sum of access times in the window |
| snap_inrange | output | TXN_W | Transactions with latency inside the range |
| snap_ovf | output | 1 | Some total saturated in the window |

## Verification
Single-beat and multi-beat transactions, taken one at a time, show whether latency and access time are measured from the right edges. Two overlapping requests with replies in order show that each beat is matched to the correct acceptance time. A run of latencies just below, on and above both range bounds shows whether the range test includes its bounds. A pair of transactions finishing on the closing edge and on the edge after it shows whether each is booked to the right window. Long runs of short transactions and two very long latencies drive the counters into saturation, followed by an idle stretch with the period at zero and then a run of empty periodic windows.

// File: rtl/busperf_pkg.sv
package busperf_pkg;
    // Position inside a response burst for the oldest outstanding request
    typedef enum logic [0:0] {
        BEAT_FIRST = 1'b0,
        BEAT_REST  = 1'b1
    } beat_phase_e;
endpackage

// File: rtl/busperf_ts_fifo.sv
module busperf_ts_fifo #(
    parameter int DEPTH = 4,
    parameter int TS_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [TS_W-1:0] push_ts,
    input  logic            pop,
    output logic [TS_W-1:0] head_ts,
    output logic            empty,
    output logic            full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TS_W-1:0] mem;
        logic [PTR_W-1:0]           wr;
        logic [PTR_W-1:0]           rd;
        logic [CNT_W-1:0]           cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        fifo_d = fifo_q;
        if (push) begin
            fifo_d.mem[fifo_q.wr] = push_ts;
            fifo_d.wr             = step(fifo_q.wr);
        end
        if (pop) begin
            fifo_d.rd = step(fifo_q.rd);
        end
        case ({push, pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    assign head_ts = fifo_q.mem[fifo_q.rd];
    assign empty   = (fifo_q.cnt == '0);
    assign full    = (fifo_q.cnt == CNT_W'(DEPTH));

    AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop)); // R3
    AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R3
endmodule

// File: rtl/busperf_txn_tracker.sv
module busperf_txn_tracker
    import busperf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TS_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_fire,
    input  logic            beat_fire,
    input  logic            beat_last,
    output logic            done,
    output logic [TS_W-1:0] done_lat,
    output logic [TS_W-1:0] done_acc
);
    typedef struct packed {
        logic [TS_W-1:0] ts;
        beat_phase_e     phase;
        logic [TS_W-1:0] lat_hold;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [TS_W-1:0] head_ts;
    logic            fifo_empty;
    logic            fifo_full;
    logic            beat_ok;
    logic [TS_W-1:0] span_now;

    busperf_ts_fifo #(.DEPTH(DEPTH), .TS_W(TS_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (req_fire),
        .push_ts (trk_q.ts),
        .pop     (done),
        .head_ts (head_ts),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    // A beat with nothing outstanding belongs to no tracked request
    assign beat_ok  = beat_fire && !fifo_empty;
    assign span_now = trk_q.ts - head_ts;

    always_comb begin
        trk_d    = trk_q;
        trk_d.ts = trk_q.ts + 1'b1;
        done     = beat_ok && beat_last;
        done_acc = span_now;
        done_lat = (trk_q.phase == BEAT_REST) ? trk_q.lat_hold : span_now;
        if (beat_ok) begin
            if (beat_last) begin
                trk_d.phase = BEAT_FIRST;
            end else if (trk_q.phase == BEAT_FIRST) begin
                trk_d.phase    = BEAT_REST;
                trk_d.lat_hold = span_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    AST_ACC_NOT_BELOW_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_acc >= done_lat)); // R2
    AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_lat != '0)); // R1
endmodule

// File: rtl/busperf_accum.sv
module busperf_accum #(
    parameter int PER_W    = 16,
    parameter int TS_W     = 16,
    parameter int TXN_W    = 16,
    parameter int CYC_W    = 32,
    parameter bit RANGE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [TS_W-1:0]  cfg_lat_lo,
    input  logic [TS_W-1:0]  cfg_lat_hi,
    input  logic             done,
    input  logic [TS_W-1:0]  done_lat,
    input  logic [TS_W-1:0]  done_acc,
    output logic             snap_valid,
    output logic [TXN_W-1:0] snap_txn,
    output logic [CYC_W-1:0] snap_lat,
    output logic [CYC_W-1:0] snap_acc,
    output logic [TXN_W-1:0] snap_inrange,
    output logic             snap_ovf
);
    typedef struct packed {
        logic [PER_W-1:0] per_cnt;
        logic [TXN_W-1:0] txn;
        logic [CYC_W-1:0] lat;
        logic [CYC_W-1:0] acc;
        logic [TXN_W-1:0] inr;
        logic             ovf;
        logic             s_valid;
        logic [TXN_W-1:0] s_txn;
        logic [CYC_W-1:0] s_lat;
        logic [CYC_W-1:0] s_acc;
        logic [TXN_W-1:0] s_inr;
        logic             s_ovf;
    } win_t;

    win_t win_d, win_q;

    logic             in_range;
    logic             win_end;
    logic [TXN_W:0]   txn_sum;
    logic [TXN_W:0]   inr_sum;
    logic [CYC_W:0]   lat_sum;
    logic [CYC_W:0]   acc_sum;

    // Result bit TXN_W flags saturation
    function automatic logic [TXN_W:0] inc_sat(input logic [TXN_W-1:0] a, input logic en);
        logic [TXN_W:0] s;
        s = {1'b0, a} + {{TXN_W{1'b0}}, en};
        if (s[TXN_W]) return {1'b1, {TXN_W{1'b1}}};
        return s;
    endfunction

    // Result bit CYC_W flags saturation
    function automatic logic [CYC_W:0] add_sat(input logic [CYC_W-1:0] a, input logic [TS_W-1:0] b);
        logic [CYC_W:0] s;
        s = {1'b0, a} + (CYC_W + 1)'(b);
        if (s[CYC_W]) return {1'b1, {CYC_W{1'b1}}};
        return s;
    endfunction

    generate
        if (RANGE_EN) begin : g_range
            assign in_range = done && (done_lat >= cfg_lat_lo) && (done_lat <= cfg_lat_hi);
        end else begin : g_no_range
            assign in_range = 1'b0;
        end
    endgenerate

    assign win_end = (cfg_period != '0) && (win_q.per_cnt >= (cfg_period - PER_W'(1)));

    assign txn_sum = inc_sat(win_q.txn, done);
    assign inr_sum = inc_sat(win_q.inr, in_range);
    assign lat_sum = add_sat(win_q.lat, done ? done_lat : '0);
    assign acc_sum = add_sat(win_q.acc, done ? done_acc : '0);

    always_comb begin
        logic ovf_new;
        win_d   = win_q;
        ovf_new = win_q.ovf | txn_sum[TXN_W] | inr_sum[TXN_W]
                | lat_sum[CYC_W] | acc_sum[CYC_W];
        if (win_end) begin
            // Closing edge: its own event goes into the snapshot
            win_d.s_valid = 1'b1;
            win_d.s_txn   = txn_sum[TXN_W-1:0];
            win_d.s_inr   = inr_sum[TXN_W-1:0];
            win_d.s_lat   = lat_sum[CYC_W-1:0];
            win_d.s_acc   = acc_sum[CYC_W-1:0];
            win_d.s_ovf   = ovf_new;
            win_d.per_cnt = '0;
            win_d.txn     = '0;
            win_d.inr     = '0;
            win_d.lat     = '0;
            win_d.acc     = '0;
            win_d.ovf     = 1'b0;
        end else begin
            win_d.s_valid = 1'b0;
            win_d.per_cnt = (cfg_period == '0) ? '0 : win_q.per_cnt + 1'b1;
            win_d.txn     = txn_sum[TXN_W-1:0];
            win_d.inr     = inr_sum[TXN_W-1:0];
            win_d.lat     = lat_sum[CYC_W-1:0];
            win_d.acc     = acc_sum[CYC_W-1:0];
            win_d.ovf     = ovf_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign snap_valid   = win_q.s_valid;
    assign snap_txn     = win_q.s_txn;
    assign snap_lat     = win_q.s_lat;
    assign snap_acc     = win_q.s_acc;
    assign snap_inrange = win_q.s_inr;
    assign snap_ovf     = win_q.s_ovf;

    AST_NO_SNAP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_period == '0) |=> !snap_valid); // R7
    AST_TXN_NEVER_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> (win_q.txn >= $past(win_q.txn))); // R8
    AST_LAT_NEVER_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> (win_q.lat >= $past(win_q.lat))); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.ovf && !win_end) |=> win_q.ovf); // R8
    AST_INRANGE_LE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |-> (snap_inrange <= snap_txn)); // R4
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(snap_txn)); // R5
endmodule

// File: rtl/busperf_window.sv
module busperf_window #(
    parameter int DEPTH    = 4,
    parameter int PER_W    = 16,
    parameter int TS_W     = 16,
    parameter int TXN_W    = 16,
    parameter int CYC_W    = 32,
    parameter bit RANGE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [TS_W-1:0]  cfg_lat_lo,
    input  logic [TS_W-1:0]  cfg_lat_hi,
    input  logic             req_valid,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic             rsp_ready,
    input  logic             rsp_last,
    output logic             snap_valid,
    output logic [TXN_W-1:0] snap_txn,
    output logic [CYC_W-1:0] snap_lat,
    output logic [CYC_W-1:0] snap_acc,
    output logic [TXN_W-1:0] snap_inrange,
    output logic             snap_ovf
);
    logic            req_fire;
    logic            beat_fire;
    logic            done;
    logic [TS_W-1:0] done_lat;
    logic [TS_W-1:0] done_acc;

    assign req_fire  = req_valid & req_ready;
    assign beat_fire = rsp_valid & rsp_ready;

    busperf_txn_tracker #(.DEPTH(DEPTH), .TS_W(TS_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .beat_fire (beat_fire),
        .beat_last (rsp_last),
        .done      (done),
        .done_lat  (done_lat),
        .done_acc  (done_acc)
    );

    busperf_accum #(
        .PER_W    (PER_W),
        .TS_W     (TS_W),
        .TXN_W    (TXN_W),
        .CYC_W    (CYC_W),
        .RANGE_EN (RANGE_EN)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_period   (cfg_period),
        .cfg_lat_lo   (cfg_lat_lo),
        .cfg_lat_hi   (cfg_lat_hi),
        .done         (done),
        .done_lat     (done_lat),
        .done_acc     (done_acc),
        .snap_valid   (snap_valid),
        .snap_txn     (snap_txn),
        .snap_lat     (snap_lat),
        .snap_acc     (snap_acc),
        .snap_inrange (snap_inrange),
        .snap_ovf     (snap_ovf)
    );

    AST_PULSE_AFTER_DONE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_valid && (cfg_period > 1)) |=> !snap_valid); // R5
endmodule

// File: tb/tb_busperf_window.sv
`timescale 1ns/1ps
module tb_busperf_window;
    localparam int TXN_W = 4;
    localparam int CYC_W = 8;
    localparam int TS_W  = 8;
    localparam int PER_W = 8;
    localparam int TXN_MAX = (1 << TXN_W) - 1;
    localparam int CYC_MAX = (1 << CYC_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PER_W-1:0] cfg_period = '0;
    logic [TS_W-1:0]  cfg_lat_lo = '0;
    logic [TS_W-1:0]  cfg_lat_hi = '1;
    logic             req_valid = 1'b0;
    logic             req_ready = 1'b1;
    logic             rsp_valid = 1'b0;
    logic             rsp_ready = 1'b1;
    logic             rsp_last  = 1'b0;
    logic             snap_valid;
    logic [TXN_W-1:0] snap_txn;
    logic [CYC_W-1:0] snap_lat;
    logic [CYC_W-1:0] snap_acc;
    logic [TXN_W-1:0] snap_inrange;
    logic             snap_ovf;

    int checks = 0;
    int errors = 0;
    int e_txn = 0, e_lat = 0, e_acc = 0, e_inr = 0, e_ovf = 0;

    always #2 clk = ~clk;

    busperf_window #(
        .DEPTH(4), .PER_W(PER_W), .TS_W(TS_W), .TXN_W(TXN_W), .CYC_W(CYC_W), .RANGE_EN(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period),
        .cfg_lat_lo(cfg_lat_lo), .cfg_lat_hi(cfg_lat_hi),
        .req_valid(req_valid), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_last(rsp_last),
        .snap_valid(snap_valid), .snap_txn(snap_txn), .snap_lat(snap_lat),
        .snap_acc(snap_acc), .snap_inrange(snap_inrange), .snap_ovf(snap_ovf)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_exp();
        e_txn = 0; e_lat = 0; e_acc = 0; e_inr = 0; e_ovf = 0;
    endtask

    // Bench model of one completed transaction with saturation
    task automatic book(input int lat, input int beats);
        int acc;
        acc = lat + beats - 1;
        if (e_txn + 1 > TXN_MAX) begin e_txn = TXN_MAX; e_ovf = 1; end else e_txn++;
        if (e_lat + lat > CYC_MAX) begin e_lat = CYC_MAX; e_ovf = 1; end else e_lat += lat;
        if (e_acc + acc > CYC_MAX) begin e_acc = CYC_MAX; e_ovf = 1; end else e_acc += acc;
        if (lat >= int'(cfg_lat_lo) && lat <= int'(cfg_lat_hi)) begin
            if (e_inr + 1 > TXN_MAX) begin e_inr = TXN_MAX; e_ovf = 1; end else e_inr++;
        end
    endtask

    // One request, then its burst; starts and ends at a falling edge
    task automatic issue(input int lat, input int beats);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (lat - 1) @(negedge clk);
        for (int b = 0; b < beats; b++) begin
            rsp_valid = 1'b1;
            rsp_last  = (b == beats - 1);
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        rsp_last  = 1'b0;
        book(lat, beats);
    endtask

    // Close a window on the next edge and compare it with the bench totals
    task automatic flush_check(input string req);
        cfg_period = PER_W'(1);
        @(negedge clk);
        check(req, "snap_valid", int'(snap_valid), 1);
        check(req, "snap_txn", int'(snap_txn), e_txn);
        check(req, "snap_lat", int'(snap_lat), e_lat);
        check(req, "snap_acc", int'(snap_acc), e_acc);
        check(req, "snap_inrange", int'(snap_inrange), e_inr);
        check(req, "snap_ovf", int'(snap_ovf), e_ovf);
        cfg_period = '0;
        clear_exp();
    endtask

    task automatic t_reset();
        check("R9", "snap_valid", int'(snap_valid), 0);
        check("R9", "snap_txn", int'(snap_txn), 0);
        check("R9", "snap_lat", int'(snap_lat), 0);
        check("R9", "snap_acc", int'(snap_acc), 0);
        check("R9", "snap_inrange", int'(snap_inrange), 0);
        check("R9", "snap_ovf", int'(snap_ovf), 0);
    endtask

    task automatic t_single();
        issue(3, 1); // R1: latency 3, access 3
        flush_check("R1");
    endtask

    task automatic t_bursts();
        issue(4, 4); // R2: access 7
        issue(4, 2); // R2: access 5
        flush_check("R2");
    endtask

    task automatic t_overlap();
        // R3: two accepts back to back, replies in order
        req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rsp_valid = 1'b1; rsp_last = 1'b1;
        @(negedge clk);
        rsp_last = 1'b0;
        @(negedge clk);
        rsp_last = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_last = 1'b0;
        book(4, 1);
        book(4, 2);
        flush_check("R3");
    endtask

    task automatic t_range();
        cfg_lat_lo = TS_W'(3);
        cfg_lat_hi = TS_W'(5);
        issue(2, 1);
        issue(3, 1);
        issue(5, 1);
        issue(6, 1);
        flush_check("R4"); // R4: latencies 3 and 5 counted only
        cfg_lat_lo = '0;
        cfg_lat_hi = '1;
    endtask

    task automatic t_disabled();
        int seen;
        seen = 0;
        issue(2, 2);
        for (int i = 0; i < 20; i++) begin
            if (snap_valid) seen++;
            @(negedge clk);
        end
        issue(1, 1);
        check("R7", "pulses while period is 0", seen, 0);
        flush_check("R7"); // both transactions still accumulated
    endtask

    task automatic t_boundary();
        int pulses;
        @(negedge clk);
        cfg_period = PER_W'(8);
        repeat (5) @(negedge clk);
        req_valid = 1'b1;             // accepted on edge 6
        @(negedge clk);               // second accept on edge 7
        @(negedge clk);
        req_valid = 1'b0;
        rsp_valid = 1'b1; rsp_last = 1'b1; // first completes on edge 8
        @(negedge clk);
        check("R6", "closing-edge snap_valid", int'(snap_valid), 1);
        check("R6", "closing-edge snap_txn", int'(snap_txn), 1);
        check("R6", "closing-edge snap_lat", int'(snap_lat), 2);
        @(negedge clk);               // second completes on edge 9
        rsp_valid = 1'b0; rsp_last = 1'b0;
        check("R5", "pulse lasts one cycle", int'(snap_valid), 0);
        check("R5", "snapshot held", int'(snap_txn), 1);
        repeat (7) @(negedge clk);    // edge 16
        check("R6", "next window snap_valid", int'(snap_valid), 1);
        check("R6", "next window snap_txn", int'(snap_txn), 1);
        check("R6", "next window snap_acc", int'(snap_acc), 2);
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (snap_valid) pulses++;
        end
        check("R5", "pulses in one period", pulses, 1);
        check("R5", "empty window snap_txn", int'(snap_txn), 0);
        cfg_period = '0;
        @(negedge clk);
        clear_exp();
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 18; i++) issue(1, 1);
        flush_check("R8"); // txn and in-range stick at 15, flag set
        issue(150, 1);
        issue(150, 1);
        flush_check("R8"); // latency and access stick at 255
        flush_check("R8"); // empty window, flag clear again
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_bursts();
        t_overlap();
        t_range();
        t_disabled();
        t_boundary();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule